// File: doc/BRIEF.md
# Debug Emulator-Mode Exception Tracker

This block sits beside a processor's exception unit and tracks the emulator-mode state bit. The bit is set when a breakpoint-driven debug interrupt is taken. While it is set, an alternate address-space select routes instruction and operand references to a separate space. The debug service routine can itself be interrupted by normal interrupts or by other exceptions, and these may nest. Each exception taken saves the live emulator-mode bit and then clears it. The saved copy goes into the fault-status field of the new exception frame, at bit 17 of the frame longword.

When the handler returns, its RTE presents the stacked longword. Bit 17 of that longword restores the mode. If the bit is set, emulator mode comes back and the debug-entry status code is signalled again, exactly as on the first entry.

All requests are evaluated only on instruction boundaries. A breakpoint trigger outranks every normal interrupt level and the generic exception request. When a breakpoint and another exception arrive on the same boundary, the debug interrupt is taken first. The other exception is then taken on the following cycle, nested inside the debug routine.

Top module: `dbg_emu_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it, `emu_mode`, `alt_space`, `dbg_taken`, `exc_take` and `frame_fs1` are 0 and `pst` is the idle code 0x0.
- R2: A boundary with `bkpt_trig` high and also a normal interrupt or `exc_req` takes the debug interrupt first. On the next cycle, the other exception is taken with `frame_fs1` = 1 and `emu_mode` cleared.
- R3: A boundary with `bkpt_trig` high sets `emu_mode` and `alt_space` to 1 and pulses `dbg_taken` for one cycle. All three are registered outputs, valid after the sampling edge.
- R4: Each debug entry or re-entry drives `pst` = 0xD for exactly 3 consecutive cycles, starting with the cycle in which `dbg_taken` is high. At all other times `pst` is 0x0.
- R5: `bkpt_trig`, `ipl_req` and `exc_req` have no effect while `insn_bnd` is low.
- R6: A boundary with an exception request and no breakpoint does three things. It copies the pre-edge `emu_mode` into `frame_fs1`, clears `emu_mode`, and pulses `exc_take` for one cycle. `frame_fs1` then holds until the next exception is taken.
- R7: `frame_out` equals `frame_in` with bit 17 replaced by `frame_fs1`. Every other bit passes through unchanged.
- R8: An `rte_strobe` cycle with no exception taken loads `emu_mode` from `stk_word` bit 17. If that bit is 1, it also pulses `dbg_taken` and starts the 0xD sequence. If it is 0, `emu_mode` becomes 0 with no pulse and no status change.
- R9: An `ipl_req` of 0 means no normal interrupt. Any nonzero level is a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bkpt_trig | input | 1 | Breakpoint trigger configured for a debug interrupt |
| ipl_req | input | IPL_W (3) | Encoded normal interrupt level, 0 = none |
| insn_bnd | input | 1 | Instruction-boundary strobe, requests sampled here |
| exc_req | input | 1 | Generic exception request |
| rte_strobe | input | 1 | Return-from-exception in progress |
| stk_word | input | WORD_W (32) | Stacked status longword read during RTE |
| frame_in | input | WORD_W (32) | Frame longword from the exception unit |
| emu_mode | output | 1 | Live emulator-mode bit |
| alt_space | output | 1 | Alternate address-space select |
| pst | output | 4 | Processor-status code (0x0 idle, 0xD debug entry) |
| dbg_taken | output | 1 | One-cycle pulse on debug entry or re-entry |
| exc_take | output | 1 | One-cycle pulse when an exception is taken |
| frame_fs1 | output | 1 | Saved emulator-mode bit for the new frame |
| frame_out | output | WORD_W (32) | Frame longword with bit 17 inserted |

## Verification
The bench drives a breakpoint on the same boundary as a level-7 interrupt. A design that took the interrupt first, or dropped it, would show `exc_take` in the wrong cycle or a saved bit of 0. It nests an interrupt in the debug routine and returns with bit 17 set, then with bit 17 clear. A tracker that failed to save or restore the bit would leave emulator mode wrong, or would miss or spuriously raise the 0xD sequence. It counts the 0xD cycles on entry and re-entry, so an off-by-one hold length is exposed. It also presents requests with the boundary strobe low and level 0 with the strobe high, so a design that samples outside boundaries or treats level 0 as a request would change mode.

// File: rtl/dbg_emu_pkg.sv
package dbg_emu_pkg;

    localparam int PST_W = 4;

    typedef logic [PST_W-1:0] pst_t;

    localparam pst_t PST_IDLE = 4'h0;
    localparam pst_t PST_DBG  = 4'hD;

    // Outcome of one cycle of request arbitration
    typedef struct packed {
        logic dbg;    // take the debug interrupt
        logic exc;    // take a normal interrupt / exception
        logic defer;  // another exception waits behind the debug entry
    } take_s;

    function automatic logic any_level(input logic [7:0] lvl);
        return |lvl;
    endfunction

endpackage

// File: rtl/dbg_emu_arb.sv
module dbg_emu_arb
    import dbg_emu_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic             insn_bnd,
    input  logic             bkpt_trig,
    input  logic [IPL_W-1:0] ipl_req,
    input  logic             exc_req,
    input  logic             pend,
    output take_s            take
);
    logic [7:0] lvl_ext;
    logic       other;

    always_comb begin
        lvl_ext = '0;
        lvl_ext[IPL_W-1:0] = ipl_req;
        other = exc_req | any_level(lvl_ext);
        // a deferred exception owns the cycle after a debug entry
        take.dbg   = insn_bnd & bkpt_trig & ~pend;
        take.exc   = pend | (insn_bnd & ~bkpt_trig & other);
        take.defer = take.dbg & other;
    end

endmodule

// File: rtl/dbg_emu_state.sv
module dbg_emu_state
    import dbg_emu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FS_BIT = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  take_s             take,
    input  logic              rte_strobe,
    input  logic [WORD_W-1:0] stk_word,
    output logic              emu_q,
    output logic              saved_q,
    output logic              pend_q,
    output logic              enter,
    output logic              dbg_pulse_q,
    output logic              exc_pulse_q
);
    logic rte_ok;

    always_comb begin
        rte_ok = rte_strobe & ~take.dbg & ~take.exc;
        enter  = take.dbg | (rte_ok & stk_word[FS_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emu_q       <= 1'b0;
            saved_q     <= 1'b0;
            pend_q      <= 1'b0;
            dbg_pulse_q <= 1'b0;
            exc_pulse_q <= 1'b0;
        end else begin
            dbg_pulse_q <= enter;
            exc_pulse_q <= take.exc;
            if (take.dbg) begin
                saved_q <= emu_q;
                emu_q   <= 1'b1;
                pend_q  <= take.defer;
            end else if (take.exc) begin
                saved_q <= emu_q;
                emu_q   <= 1'b0;
                pend_q  <= 1'b0;
            end else if (rte_ok) begin
                emu_q   <= stk_word[FS_BIT];
            end
        end
    end

endmodule

// File: rtl/dbg_pst_gen.sv
module dbg_pst_gen
    import dbg_emu_pkg::*;
#(
    parameter int PST_HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    output pst_t pst
);
    localparam int CNT_W = $clog2(PST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(PST_HOLD);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (enter) begin
            cnt_q <= HOLD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pst = (cnt_q != '0) ? PST_DBG : PST_IDLE;

endmodule

// File: rtl/dbg_emu_tracker.sv
module dbg_emu_tracker
    import dbg_emu_pkg::*;
#(
    parameter int IPL_W    = 3,
    parameter int WORD_W   = 32,
    parameter int FS_BIT   = 17,
    parameter int PST_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bkpt_trig,
    input  logic [IPL_W-1:0]  ipl_req,
    input  logic              insn_bnd,
    input  logic              exc_req,
    input  logic              rte_strobe,
    input  logic [WORD_W-1:0] stk_word,
    input  logic [WORD_W-1:0] frame_in,
    output logic              emu_mode,
    output logic              alt_space,
    output logic [3:0]        pst,
    output logic              dbg_taken,
    output logic              exc_take,
    output logic              frame_fs1,
    output logic [WORD_W-1:0] frame_out
);
    take_s take;
    logic  emu_q, saved_q, pend_q, enter;
    pst_t  pst_code;

    dbg_emu_arb #(.IPL_W(IPL_W)) u_arb (
        .insn_bnd  (insn_bnd),
        .bkpt_trig (bkpt_trig),
        .ipl_req   (ipl_req),
        .exc_req   (exc_req),
        .pend      (pend_q),
        .take      (take)
    );

    dbg_emu_state #(.WORD_W(WORD_W), .FS_BIT(FS_BIT)) u_state (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .rte_strobe  (rte_strobe),
        .stk_word    (stk_word),
        .emu_q       (emu_q),
        .saved_q     (saved_q),
        .pend_q      (pend_q),
        .enter       (enter),
        .dbg_pulse_q (dbg_taken),
        .exc_pulse_q (exc_take)
    );

    dbg_pst_gen #(.PST_HOLD(PST_HOLD)) u_pst (
        .clk   (clk),
        .rst   (rst),
        .enter (enter),
        .pst   (pst_code)
    );

    assign emu_mode  = emu_q;
    assign alt_space = emu_q;
    assign pst       = pst_code;
    assign frame_fs1 = saved_q;

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_frame
        if (gi == FS_BIT) begin : g_fs
            assign frame_out[gi] = saved_q;
        end else begin : g_pass
            assign frame_out[gi] = frame_in[gi];
        end
    end

endmodule

// File: rtl/dbg_emu_chk.sv
module dbg_emu_chk #(
    parameter int WORD_W = 32,
    parameter int FS_BIT = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_bnd,
    input logic              rte_strobe,
    input logic [WORD_W-1:0] stk_word,
    input logic              emu_mode,
    input logic [3:0]        pst,
    input logic              dbg_taken,
    input logic              exc_take
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (pst == 4'h0 && !emu_mode && !dbg_taken && !exc_take));

    // R3
    entry_sets_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_taken |-> emu_mode);

    // R4
    entry_pst_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_taken |-> pst == 4'hD);

    // R4
    pst_code_chk: assert property (@(posedge clk) disable iff (rst)
        (pst == 4'h0 || pst == 4'hD));

    // R6
    exc_clears_chk: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> !emu_mode);

    // R5
    no_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!insn_bnd && !rte_strobe && !dbg_taken) |=> $stable(emu_mode));

    // R8
    rte_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (rte_strobe && !insn_bnd && !dbg_taken && !stk_word[FS_BIT])
            |=> (!emu_mode && !dbg_taken));

endmodule

bind dbg_emu_tracker dbg_emu_chk #(.WORD_W(WORD_W), .FS_BIT(FS_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_bnd   (insn_bnd),
    .rte_strobe (rte_strobe),
    .stk_word   (stk_word),
    .emu_mode   (emu_mode),
    .pst        (pst),
    .dbg_taken  (dbg_taken),
    .exc_take   (exc_take)
);

// File: tb/tb_dbg_emu_tracker.sv
module tb_dbg_emu_tracker;

    localparam logic [31:0] FRAME = 32'hA5A7_5A5A;

    logic        clk = 1'b0;
    logic        rst;
    logic        bkpt_trig, insn_bnd, exc_req, rte_strobe;
    logic [2:0]  ipl_req;
    logic [31:0] stk_word, frame_in;
    logic        emu_mode, alt_space, dbg_taken, exc_take, frame_fs1;
    logic [3:0]  pst;
    logic [31:0] frame_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       emu;
        logic [3:0] pst;
        logic       dbg;
        logic       exc;
        logic       fs1;
        string      tag;
    } exp_s;

    exp_s sb[$];

    always #4 clk = ~clk;

    dbg_emu_tracker dut (
        .clk(clk), .rst(rst), .bkpt_trig(bkpt_trig), .ipl_req(ipl_req),
        .insn_bnd(insn_bnd), .exc_req(exc_req), .rte_strobe(rte_strobe),
        .stk_word(stk_word), .frame_in(frame_in), .emu_mode(emu_mode),
        .alt_space(alt_space), .pst(pst), .dbg_taken(dbg_taken),
        .exc_take(exc_take), .frame_fs1(frame_fs1), .frame_out(frame_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp(input exp_s e);
        logic [31:0] fexp;
        fexp = (FRAME & ~32'h0002_0000) | (32'(e.fs1) << 17);  // R7
        chk(e.tag, "emu_mode",  32'(emu_mode),  32'(e.emu));
        chk(e.tag, "alt_space", 32'(alt_space), 32'(e.emu));
        chk(e.tag, "pst",       32'(pst),       32'(e.pst));
        chk(e.tag, "dbg_taken", 32'(dbg_taken), 32'(e.dbg));
        chk(e.tag, "exc_take",  32'(exc_take),  32'(e.exc));
        chk(e.tag, "frame_fs1", 32'(frame_fs1), 32'(e.fs1));
        chk(e.tag, "frame_out R7", frame_out, fexp);
    endtask

    // driver: apply one cycle of stimulus, queue the result expected after the edge
    task automatic step(input logic b, input logic bk, input logic [2:0] ip,
                        input logic ex, input logic rt, input logic s17,
                        input logic ee, input logic [3:0] ep, input logic ed,
                        input logic exx, input logic ef, input string tag);
        exp_s e;
        @(negedge clk);
        insn_bnd   = b;
        bkpt_trig  = bk;
        ipl_req    = ip;
        exc_req    = ex;
        rte_strobe = rt;
        stk_word   = s17 ? 32'h0002_1234 : 32'h0000_1234;
        e.emu = ee; e.pst = ep; e.dbg = ed; e.exc = exx; e.fs1 = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) cmp(sb.pop_front());
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bkpt_trig = 0; insn_bnd = 0; exc_req = 0; rte_strobe = 0;
        ipl_req = 0; stk_word = 0; frame_in = FRAME;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        begin
            exp_s r;
            r.emu = 0; r.pst = 4'h0; r.dbg = 0; r.exc = 0; r.fs1 = 0; r.tag = "R1";
            cmp(r);
        end
        //   bnd bk ipl exc rte s17 | emu pst dbg exc fs1
        step(0, 1, 3'd5, 1, 0, 0,   0, 4'h0, 0, 0, 0, "R5");
        step(1, 1, 3'd0, 0, 0, 0,   1, 4'hD, 1, 0, 0, "R3");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 0, "R4");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 0, "R4");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'h0, 0, 0, 0, "R4");
        step(1, 0, 3'd0, 0, 0, 0,   1, 4'h0, 0, 0, 0, "R9");
        step(1, 0, 3'd3, 0, 0, 0,   0, 4'h0, 0, 1, 1, "R6");
        step(0, 0, 3'd0, 0, 0, 0,   0, 4'h0, 0, 0, 1, "R6");
        step(0, 0, 3'd0, 0, 1, 1,   1, 4'hD, 1, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'h0, 0, 0, 1, "R4");
        step(1, 0, 3'd0, 1, 0, 0,   0, 4'h0, 0, 1, 1, "R6");
        step(0, 0, 3'd0, 0, 1, 0,   0, 4'h0, 0, 0, 1, "R8");
        step(1, 0, 3'd0, 1, 0, 0,   0, 4'h0, 0, 1, 0, "R6");
        step(1, 1, 3'd7, 0, 0, 0,   1, 4'hD, 1, 0, 0, "R2");
        step(0, 0, 3'd0, 0, 0, 0,   0, 4'hD, 0, 1, 1, "R2");
        step(0, 0, 3'd0, 0, 0, 0,   0, 4'hD, 0, 0, 1, "R2");
        step(0, 0, 3'd0, 0, 0, 0,   0, 4'h0, 0, 0, 1, "R4");
        step(0, 0, 3'd0, 0, 1, 1,   1, 4'hD, 1, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'hD, 0, 0, 1, "R8");
        step(0, 0, 3'd0, 0, 0, 0,   1, 4'h0, 0, 0, 1, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule